// File: doc/BRIEF.md
# Processor Bus Write Capture into On-Chip RAM

This block lets an 8-bit microprocessor store bytes into a small FPGA memory by writing to a peripheral window. The processor side supplies its bus clock, a read/write strobe, an active-low select, three register address lines and eight data lines. All of these are inputs only and are asynchronous to the FPGA. The block samples everything on one fast system clock, nominally 100 MHz. It finds the bus clock edges through synchronizers and commits one RAM write for each qualified processor write cycle.

The processor may run its bus clock anywhere from about 1.8 MHz to 12 MHz. The FPGA only sees a bus clock edge a few system cycles after it happens. To compensate, address, data and control travel through delay lines matched to the synchronizer depth. The byte committed is therefore the one present on the bus in the last sample before the bus clock fell. A synchronous read port with one cycle of latency exposes the stored contents.

Top module: `bus_write_capture`

## Requirements
- R1: A synchronous reset clears all eight 8-bit entries to zero, and `rd_data` reads zero after reset.
- R2: A bus cycle is a write when `bus_phi2` is high, `bus_cs_n` is 0 and `bus_rnw` is 0. Such a cycle stores its byte into the entry whose index equals the 3-bit `bus_addr`.
- R3: The stored byte is the value on `bus_data` just before `bus_phi2` falls. Values driven earlier in the high phase or after the fall are not stored.
- R4: The entry index is taken while `bus_phi2` is high. Address changes during the low phase do not redirect the write.
- R5: A cycle with `bus_rnw` = 1 changes no entry.
- R6: A cycle with `bus_cs_n` = 1 changes no entry.
- R7: Each qualified bus cycle produces exactly one write, however long `bus_phi2` stays high, and the byte written is the last one before the fall.
- R8: Captures are correct for bus clock rates of 12 MHz and 1.8 MHz.
- R9: After reset, no write happens until a full low, high, low sequence of `bus_phi2` has been seen. A cycle whose high phase spans the reset release writes nothing.
- R10: `rd_data` returns the entry selected by `rd_addr` one system clock after `rd_addr` is presented.
- R11: A stored byte is readable when `rd_addr` is presented six system clock cycles after `bus_phi2` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, asynchronous to the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_phi2 | input | 1 | Processor bus clock |
| bus_cs_n | input | 1 | Active-low select for this peripheral |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 3 | Register index on the bus |
| bus_data | input | 8 | Processor write data |
| rd_addr | input | 3 | Read port index |
| rd_data | output | 8 | Read port data, registered |

## Verification
Suppose the edge detector or the arming state is wrong. One bus cycle would then be missed, doubled, or committed after a reset that landed mid-cycle, and the next read of that entry, about six system clocks after the fall, would show a stale or nonzero byte. If the data delay line is misaligned with the synchronizer, the stored byte is one from after the fall. The bench detects this because it drives a scrambled value 10 ns after every fall. A misaligned address path writes to an entry the bench never targeted, and later reads of that entry expose it.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [1:0] {
    ARM_SETTLE   = 2'd0,
    ARM_WAIT_LOW = 2'd1,
    ARM_READY    = 2'd2
  } arm_state_e;
endpackage

// File: rtl/bwc_sync.sv
module bwc_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bwc_delay.sv
module bwc_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] tap [DEPTH+1];
  assign tap[0] = d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap[g+1] <= '0;
      else     tap[g+1] <= tap[g];
    end
  end

  assign q = tap[DEPTH];
endmodule

// File: rtl/bwc_cycle_ctl.sv
module bwc_cycle_ctl
  import bwc_pkg::*;
#(
  parameter int AW     = 3,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phi_s,
  input  logic          csn_s,
  input  logic          rnw_s,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] data_a,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CW = $clog2(STAGES + 2);

  arm_state_e    arm_q;
  logic [CW-1:0] settle_q;
  logic          phi_q;
  logic          in_cycle_q;
  logic          pend_q;
  logic [AW-1:0] addr_hold_q;
  logic          ready, rise, fall, qual;

  assign ready = (arm_q == ARM_READY);
  assign rise  = ready &  phi_s & ~phi_q;
  assign fall  = ready & ~phi_s &  phi_q;
  assign qual  = (in_cycle_q | rise) & phi_s & ~csn_s & ~rnw_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q    <= ARM_SETTLE;
      settle_q <= '0;
      phi_q    <= 1'b0;
    end else begin
      phi_q <= phi_s;
      case (arm_q)
        ARM_SETTLE: begin
          if (settle_q == CW'(STAGES)) arm_q <= ARM_WAIT_LOW;
          else                         settle_q <= settle_q + 1'b1;
        end
        ARM_WAIT_LOW: if (!phi_s) arm_q <= ARM_READY;
        default: arm_q <= ARM_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cycle_q  <= 1'b0;
      pend_q      <= 1'b0;
      addr_hold_q <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (rise) begin
        in_cycle_q <= 1'b1;
        pend_q     <= 1'b0;
      end
      if (qual) begin
        pend_q      <= 1'b1;
        addr_hold_q <= addr_a;
      end
      if (fall) begin
        in_cycle_q <= 1'b0;
        pend_q     <= 1'b0;
        if (in_cycle_q && pend_q) begin
          wr_en   <= 1'b1;
          wr_addr <= addr_hold_q;
          wr_data <= data_a;
        end
      end
    end
  end

  // checker state: commits seen since the last detected rising edge
  logic [1:0] commits_q;
  always_ff @(posedge clk) begin
    if (rst)                           commits_q <= '0;
    else if (rise)                     commits_q <= '0;
    else if (wr_en && commits_q != 2'd3) commits_q <= commits_q + 1'b1;
  end

  p_one_commit_per_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (commits_q == 2'd0));
  p_commit_follows_fall_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(fall));
  p_no_commit_unarmed_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(arm_q == ARM_READY));
  p_commit_needs_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(pend_q && in_cycle_q));
endmodule

// File: rtl/bwc_store.sv
module bwc_store #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    p_entry_cleared_r1: assert property (@(posedge clk)
      rst |=> (mem[g] == '0));
    p_entry_held_r6: assert property (@(posedge clk) disable iff (rst)
      !(we && waddr == AW'(g)) |=> $stable(mem[g]));
  end
endmodule

// File: rtl/bus_write_capture.sv
module bus_write_capture #(
  parameter int AW     = 3,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_phi2,
  input  logic          bus_cs_n,
  input  logic          bus_rnw,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DATA_DLY = STAGES + 1;

  logic [2:0]    ctl_s;
  logic [AW-1:0] addr_a;
  logic [DW-1:0] data_a;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  bwc_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst),
    .d({bus_cs_n, bus_rnw, bus_phi2}),
    .q(ctl_s)
  );

  bwc_delay #(.W(AW), .DEPTH(STAGES)) u_addr_dly (
    .clk(clk), .rst(rst), .d(bus_addr), .q(addr_a)
  );

  bwc_delay #(.W(DW), .DEPTH(DATA_DLY)) u_data_dly (
    .clk(clk), .rst(rst), .d(bus_data), .q(data_a)
  );

  bwc_cycle_ctl #(.AW(AW), .DW(DW), .STAGES(STAGES)) u_ctl (
    .clk(clk), .rst(rst),
    .phi_s(ctl_s[0]), .rnw_s(ctl_s[1]), .csn_s(ctl_s[2]),
    .addr_a(addr_a), .data_a(data_a),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  bwc_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  p_read_zero_after_reset_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0));
endmodule

// File: tb/test_bus_write_capture.sv
`timescale 1ns/1ps
module test_bus_write_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_phi2 = 1'b0;
  logic       bus_cs_n = 1'b1;
  logic       bus_rnw = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic [7:0] exp_mem [8];

  always #2 clk = ~clk;

  bus_write_capture i_bus_write_capture (
    .clk(clk), .rst(rst), .bus_phi2(bus_phi2), .bus_cs_n(bus_cs_n),
    .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_data(bus_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // present address at a falling edge, sample one cycle later (R10)
  task automatic read_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk) rd_addr = a;
    @(negedge clk) check(req, rd_data, exp);
  endtask

  task automatic bus_cycle(input logic wr, input logic sel, input logic [2:0] a,
                           input logic [7:0] d, input real lo_ns, input real hi_ns,
                           input real tail_ns);
    bus_addr = a; bus_rnw = ~wr; bus_cs_n = ~sel; bus_data = ~d;
    #(lo_ns);
    bus_phi2 = 1'b1;
    #(hi_ns * 0.5);
    bus_data = d;
    #(hi_ns * 0.5);
    bus_phi2 = 1'b0;
    #10;
    bus_data = d ^ 8'h3c; bus_addr = a ^ 3'h5; bus_cs_n = 1'b1; bus_rnw = 1'b1;
    #(tail_ns);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) read_chk("R1 reset clear", 3'(i), 8'h00);
  endtask

  task automatic t_fast;
    for (int i = 0; i < 8; i++) begin
      bus_cycle(1'b1, 1'b1, 3'(i), 8'(8'h10 + i * 7), 41.7, 41.7, 60.0);
      exp_mem[i] = 8'(8'h10 + i * 7);
    end
    for (int i = 0; i < 8; i++) read_chk("R2 R8 R4 12MHz write", 3'(i), exp_mem[i]);
  endtask

  task automatic t_slow;
    bus_cycle(1'b1, 1'b1, 3'd2, 8'hc3, 277.0, 278.0, 60.0);
    bus_cycle(1'b1, 1'b1, 3'd5, 8'h0f, 277.0, 278.0, 60.0);
    exp_mem[2] = 8'hc3; exp_mem[5] = 8'h0f;
    read_chk("R8 1.8MHz write", 3'd2, 8'hc3);
    read_chk("R8 1.8MHz write", 3'd5, 8'h0f);
  endtask

  task automatic t_data_at_fall;
    bus_addr = 3'd7; bus_rnw = 1'b0; bus_cs_n = 1'b0; bus_data = 8'h11;
    #40 bus_phi2 = 1'b1;
    #15 bus_data = 8'h22;
    #15 bus_data = 8'h99;
    #15 bus_phi2 = 1'b0;
    #8  bus_data = 8'h44; bus_addr = 3'd1; bus_cs_n = 1'b1; bus_rnw = 1'b1;
    #80;
    exp_mem[7] = 8'h99;
    read_chk("R3 data at fall", 3'd7, 8'h99);
    read_chk("R4 low-phase address ignored", 3'd1, exp_mem[1]);
  endtask

  task automatic t_read_cycle;
    bus_cycle(1'b0, 1'b1, 3'd3, 8'hee, 41.7, 41.7, 60.0);
    read_chk("R5 read cycle no write", 3'd3, exp_mem[3]);
  endtask

  task automatic t_cs_off;
    bus_cycle(1'b1, 1'b0, 3'd4, 8'hdd, 41.7, 41.7, 60.0);
    read_chk("R6 deselected no write", 3'd4, exp_mem[4]);
  endtask

  task automatic t_long_high;
    bus_addr = 3'd0; bus_rnw = 1'b0; bus_cs_n = 1'b0; bus_data = 8'h00;
    #40 bus_phi2 = 1'b1;
    for (int k = 0; k < 20; k++) begin
      #100 bus_data = 8'(8'h60 + k);
    end
    #50 bus_phi2 = 1'b0;
    #10 bus_data = 8'hff; bus_cs_n = 1'b1; bus_rnw = 1'b1;
    #80;
    exp_mem[0] = 8'h73;
    read_chk("R7 long high one write", 3'd0, 8'h73);
  endtask

  task automatic t_latency;
    bus_cycle(1'b1, 1'b1, 3'd6, 8'h6b, 41.7, 41.7, 0.0);
    exp_mem[6] = 8'h6b;
    // the fall was 10 ns (2.5 cycles) ago; present address about 6 cycles after it
    repeat (3) @(posedge clk);
    read_chk("R11 commit latency", 3'd6, 8'h6b);
  endtask

  task automatic t_reset_mid;
    bus_addr = 3'd6; bus_rnw = 1'b0; bus_cs_n = 1'b0; bus_data = 8'ha5;
    #40 bus_phi2 = 1'b1;
    #30;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #60 bus_phi2 = 1'b0;
    #10 bus_cs_n = 1'b1; bus_rnw = 1'b1;
    #80;
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;
    read_chk("R9 no write across reset", 3'd6, 8'h00);
    read_chk("R1 cleared by second reset", 3'd2, 8'h00);
    bus_cycle(1'b1, 1'b1, 3'd6, 8'h5a, 41.7, 41.7, 60.0);
    exp_mem[6] = 8'h5a;
    read_chk("R9 write after full sequence", 3'd6, 8'h5a);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    t_reset;
    t_fast;
    t_slow;
    t_data_at_fall;
    t_read_cycle;
    t_cs_off;
    t_long_high;
    t_latency;
    t_reset_mid;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule